// File: doc/BRIEF.md
# Integer Haar Lifting Reconstructor

This block rebuilds an integer sample stream from the coefficient pairs that an integer Haar lifting analyser produces. Each pair holds a coarse value (the rounded average of an even/odd sample pair) and a detail value (the odd sample minus the even sample). The block applies the two lifting steps in reverse order with swapped signs. It first removes the update contribution to recover the even sample, and then adds the detail back to that even sample to recover the odd sample. Because each step is undone exactly, the integer reconstruction is lossless.

A merge stage interleaves the two recovered samples into one output stream. The even sample comes first and the odd sample follows on the next enabled cycle. Since every pair yields two samples, the block accepts at most one pair every two cycles. It stalls the source through `in_ready` while the odd sample of the previous pair is still waiting. A low `en` freezes all progress.

Top module: `haar_lift_inv`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_sample` is 0. After reset is released with `en` high, `in_ready` is 1.
- R2: The first sample emitted for a pair is even = coarse − (detail >>> 1), where the shift is arithmetic (it rounds toward minus infinity) and the arithmetic is two's complement.
- R3: The second sample emitted for a pair is odd = detail + even, where even is the value recovered under R2.
- R4: When a pair is accepted on a rising edge (`pair_valid` and `in_ready` both high), `out_valid` is 1 and `out_odd` is 0 right after that edge, and `out_sample` carries the even sample.
- R5: On the next rising edge at which `en` is high after the even sample, the odd sample is emitted with `out_valid` = 1 and `out_odd` = 1.
- R6: While an odd sample is still pending, `in_ready` is 0, and a pair presented in that cycle is ignored: it produces no output.
- R7: While `en` is low, `in_ready` is 0, `out_valid` is 0, `out_sample` holds its value, and a pending odd sample is kept. That odd sample is emitted once `en` returns high.
- R8: Reconstruction is bit-exact over the full signed sample range, including the most negative and most positive samples. The detail input is one bit wider than a sample.
- R9: When pairs are offered back to back with `en` held high, `out_valid` stays high on every cycle, giving one sample per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enables computation and output progress |
| pair_valid | input | 1 | The coarse and detail inputs hold a pair |
| in_ready | output | 1 | The block can take a pair on this edge |
| coarse | input | SW | Signed coarse coefficient |
| detail | input | SW+1 | Signed detail coefficient |
| out_valid | output | 1 | `out_sample` is a new reconstructed sample |
| out_odd | output | 1 | 0: the sample is the even one; 1: the sample is the odd one |
| out_sample | output | SW | Signed reconstructed sample |

## Verification
A wrong shift or sign in the undo steps shows up on the very next output sample as a mismatch against the value obtained by forward-encoding a known sample pair. An errant merge phase shows up within one or two cycles in one of three ways: the odd sample never appears, a pair is accepted while an odd sample is still pending (an extra unexpected sample), or the ordering flag is wrong. A phase that drifts under a low `en` shows up as output activity during the stall or as a lost odd sample once `en` is raised again.

// File: rtl/haar_inv_pkg.sv
package haar_inv_pkg;
    // merge phase: whether an odd sample is waiting to be emitted
    typedef enum logic {
        PH_FREE    = 1'b0,
        PH_PENDING = 1'b1
    } merge_phase_e;
endpackage

// File: rtl/haar_inv_update.sv
// Undo of the update step: even = coarse - (detail >>> 1)
module haar_inv_update #(
    parameter int SW = 16
) (
    input  logic [SW-1:0] coarse,
    input  logic [SW:0]   detail,
    output logic [SW+1:0] even_ext
);
    localparam int EW = SW + 2;

    logic signed [EW-1:0] c_ext;
    logic signed [EW-1:0] d_ext;
    logic signed [EW-1:0] d_half;

    always_comb begin
        c_ext    = {{2{coarse[SW-1]}}, coarse};
        d_ext    = {detail[SW], detail};
        d_half   = d_ext >>> 1;
        even_ext = c_ext - d_half;
    end
endmodule

// File: rtl/haar_inv_predict.sv
// Undo of the predict step: odd = detail + even
module haar_inv_predict #(
    parameter int SW = 16
) (
    input  logic [SW:0]   detail,
    input  logic [SW+1:0] even_ext,
    output logic [SW+1:0] odd_ext
);
    localparam int EW = SW + 2;

    logic [EW-1:0] d_ext;

    always_comb begin
        d_ext   = {detail[SW], detail};
        odd_ext = d_ext + even_ext;
    end
endmodule

// File: rtl/haar_inv_merge.sv
// Interleaves recovered even/odd samples into one stream
module haar_inv_merge
    import haar_inv_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          take,
    input  logic [SW-1:0] even_in,
    input  logic [SW-1:0] odd_in,
    output logic          busy,
    output logic          out_valid,
    output logic          out_odd,
    output logic [SW-1:0] out_sample
);
    typedef struct packed {
        logic          vld;
        logic          odd;
        logic [SW-1:0] smp;
        logic [SW-1:0] hold;
        merge_phase_e  ph;
    } merge_st_t;

    merge_st_t st_d;
    merge_st_t st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (en) begin
            if (st_q.ph == PH_PENDING) begin
                st_d.vld = 1'b1;
                st_d.odd = 1'b1;
                st_d.smp = st_q.hold;
                st_d.ph  = PH_FREE;
            end else if (take) begin
                st_d.vld  = 1'b1;
                st_d.odd  = 1'b0;
                st_d.smp  = even_in;
                st_d.hold = odd_in;
                st_d.ph   = PH_PENDING;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{vld: 1'b0, odd: 1'b0, smp: '0, hold: '0, ph: PH_FREE};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = (st_q.ph == PH_PENDING);
    assign out_valid  = st_q.vld;
    assign out_odd    = st_q.odd;
    assign out_sample = st_q.smp;
endmodule

// File: rtl/haar_lift_inv.sv
module haar_lift_inv #(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          pair_valid,
    output logic          in_ready,
    input  logic [SW-1:0] coarse,
    input  logic [SW:0]   detail,
    output logic          out_valid,
    output logic          out_odd,
    output logic [SW-1:0] out_sample
);
    localparam int EW = SW + 2;

    logic [EW-1:0] even_ext;
    logic [EW-1:0] odd_ext;
    logic          busy;
    logic          take;

    haar_inv_update #(.SW(SW)) u_update (
        .coarse   (coarse),
        .detail   (detail),
        .even_ext (even_ext)
    );

    haar_inv_predict #(.SW(SW)) u_predict (
        .detail   (detail),
        .even_ext (even_ext),
        .odd_ext  (odd_ext)
    );

    assign in_ready = en & ~busy;
    assign take     = pair_valid & in_ready;

    haar_inv_merge #(.SW(SW)) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .take       (take),
        .even_in    (even_ext[SW-1:0]),
        .odd_in     (odd_ext[SW-1:0]),
        .busy       (busy),
        .out_valid  (out_valid),
        .out_odd    (out_odd),
        .out_sample (out_sample)
    );
endmodule

// File: rtl/haar_lift_inv_chk.sv
module haar_lift_inv_chk #(
    parameter int SW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          pair_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_odd,
    input logic [SW-1:0] out_sample
);
    p_even_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && in_ready) |=> (out_valid && !out_odd));

    p_odd_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_odd && en) |=> (out_valid && out_odd));

    p_busy_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_odd) |-> !in_ready);

    p_stall_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!out_valid && $stable(out_sample)));

    p_stall_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !in_ready);
endmodule

bind haar_lift_inv haar_lift_inv_chk #(.SW(SW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .pair_valid (pair_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_odd    (out_odd),
    .out_sample (out_sample)
);

// File: tb/haar_lift_inv_tb.sv
module haar_lift_inv_tb;
    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          pair_valid = 1'b0;
    logic          in_ready;
    logic [SW-1:0] coarse = '0;
    logic [SW:0]   detail = '0;
    logic          out_valid;
    logic          out_odd;
    logic [SW-1:0] out_sample;

    int total = 0;
    int bad = 0;
    int run_len = 0;
    int max_run = 0;
    logic [SW:0] exp_q[$];   // {odd flag, sample}

    always #10 clk = ~clk;

    haar_lift_inv #(.SW(SW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .pair_valid (pair_valid),
        .in_ready   (in_ready),
        .coarse     (coarse),
        .detail     (detail),
        .out_valid  (out_valid),
        .out_odd    (out_odd),
        .out_sample (out_sample)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Forward-encodes (ev, od) and queues the expected reconstruction
    task automatic send_pair(input int ev, input int od);
        int d;
        int s;
        d = od - ev;
        s = ev + (d >>> 1);
        @(negedge clk);
        pair_valid = 1'b1;
        coarse     = s[SW-1:0];
        detail     = d[SW:0];
        while (!in_ready) @(negedge clk);
        exp_q.push_back({1'b0, ev[SW-1:0]});
        exp_q.push_back({1'b1, od[SW-1:0]});
        @(posedge clk);
        #1 pair_valid = 1'b0;
    endtask

    // Scoreboard monitor: R2/R3/R4/R5/R8
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                run_len++;
                if (run_len > max_run) max_run = run_len;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected sample", int'($signed(out_sample)), 0);
                end else begin
                    logic [SW:0] e;
                    e = exp_q.pop_front();
                    check(out_odd == e[SW], e[SW] ? "R5 order flag" : "R4 order flag",
                          int'(out_odd), int'(e[SW]));
                    check(out_sample == e[SW-1:0], e[SW] ? "R3 odd sample" : "R2 even sample",
                          int'($signed(out_sample)), int'($signed(e[SW-1:0])));
                end
            end else begin
                run_len = 0;
            end
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        logic [SW-1:0] held;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
        check(out_sample == '0, "R1 sample in reset", int'(out_sample), 0);
        en = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);

        // R2/R3: varied patterns, including odd and negative details
        send_pair(10, 13);
        send_pair(-5, 4);
        send_pair(7, -8);
        send_pair(0, 0);
        send_pair(-1, -2);
        repeat (4) @(negedge clk);

        // R8: full-range extremes
        send_pair(-32768, 32767);
        send_pair(32767, -32768);
        send_pair(-32768, -32768);
        send_pair(32767, 32767);
        repeat (4) @(negedge clk);

        // R6: pair presented while odd pending is ignored
        send_pair(100, 200);
        @(negedge clk);
        check(in_ready == 1'b0, "R6 ready while pending", int'(in_ready), 0);
        pair_valid = 1'b1;
        coarse     = 16'h1234;
        detail     = 17'h00055;
        @(negedge clk);
        pair_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);

        // R7: stall with odd pending
        send_pair(-300, 450);
        @(negedge clk);
        en = 1'b0;
        held = out_sample;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R7 valid while stalled", int'(out_valid), 0);
            check(in_ready == 1'b0, "R7 ready while stalled", int'(in_ready), 0);
            check(out_sample == held, "R7 sample held", int'($signed(out_sample)),
                  int'($signed(held)));
        end
        check(exp_q.size() == 1, "R7 odd kept pending", exp_q.size(), 1);
        en = 1'b1;
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R7 odd released", exp_q.size(), 0);

        // R9: back-to-back stream keeps output valid every cycle
        max_run = 0;
        for (int i = 0; i < 8; i++) begin
            send_pair(((i * 7919) % 65536) - 32768, ((i * 4243 + 911) % 65536) - 32768);
        end
        repeat (4) @(negedge clk);
        check(max_run >= 16, "R9 sustained run", max_run, 16);

        // R2/R3/R8: sweep of patterns
        for (int i = 0; i < 40; i++) begin
            send_pair(((i * 2711 + 17) % 65536) - 32768, ((i * 12289 + 5) % 65536) - 32768);
        end
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R5 all odd emitted", exp_q.size(), 0);
        finish_run();
    end
endmodule